// File: doc/BRIEF.md
# Pre-Trigger Ring Capture Buffer

The block captures a stream of sample words into an on-chip memory used as a ring. After an arm command it writes every valid sample at the next address, and the address wraps from the top of the memory back to zero. Samples from before the trigger are therefore already stored when the trigger arrives. The trigger is qualified by the sample strobe, and only the first qualified trigger after arming counts. After it, the block writes a fixed number of further samples, which is set when the block is armed. It then stops writing and raises `done`. This keeps a window of history on both sides of the event. The number of older samples kept is the depth, minus one, minus the post-trigger count.

The physical address of the trigger sample is reported on `trig_addr`. A read port returns the frozen record in time order. The caller supplies a logical index, and the block adds the frozen write pointer to it, modulo the depth. Index 0 is therefore the oldest stored sample, and the trigger sample sits at index `DEPTH-1-post`. Arming again discards the record and starts a fresh capture.

Top module: `ring_capture`

## Requirements
- R1: After reset, `done` and `rd_valid` are low, and no sample is written until an arm pulse is seen.
- R2: An arm pulse is accepted in any state. It clears `done`, moves the write pointer to address 0 and starts waiting for a trigger. No sample is written in the arm cycle itself.
- R3: While waiting for a trigger, each cycle with `smp_valid` high writes `smp_data` at the write pointer, and the pointer then advances by one. The pointer wraps from `DEPTH-1` to 0.
- R4: The trigger is accepted only in a cycle where `trig` and `smp_valid` are both high while waiting. The sample written in that cycle is the trigger sample, and its physical address appears on `trig_addr`.
- R5: After the trigger, exactly N further valid samples are written. The pointer then freezes, and `done` rises one clock after the last of these writes. It rises one clock after the trigger when N is 0.
- R6: N is taken from `post_count` when the arm pulse is accepted, and later changes have no effect. A value of `DEPTH` or more is treated as `DEPTH-1`.
- R7: `trig` is ignored before arming, after the trigger has been accepted, and after `done`.
- R8: Cycles with `smp_valid` low write nothing and do not count toward N.
- R9: A read with `rd_en` high while `done` is high returns, one clock later, the sample at physical address (frozen pointer + `rd_idx`) mod `DEPTH`, with `rd_valid` high. Index 0 is the oldest sample, and index `DEPTH-1` is the newest.
- R10: A read request made while `done` is low leaves `rd_valid` low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Start a new capture (one-cycle pulse) |
| post_count | input | CNT_W | Requested number of samples after the trigger |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | DW | Sample word |
| trig | input | 1 | Trigger pulse, qualified by `smp_valid` |
| done | output | 1 | Capture frozen and record readable |
| trig_addr | output | $clog2(DEPTH) | Physical address of the trigger sample |
| rd_en | input | 1 | Read request |
| rd_idx | input | $clog2(DEPTH) | Logical read index, 0 = oldest sample |
| rd_valid | output | 1 | `rd_data` holds the result of the read made one cycle earlier |
| rd_data | output | DW | Read data |

## Verification
The assertions assume that `arm` is a pulse and is never held high across a capture. They also assume that `post_count` fits in 32 bits and that `rst` is applied before the first arm. With those holding, the write pointer moves by exactly one per write and otherwise holds. The stimulus keeps within these limits: it drives `arm` for single cycles only, starts after a reset, and changes `post_count` only after arming. It also places invalid cycles that carry `trig` between valid samples, so the strobe qualification is exercised without breaking the pulse assumption.

// File: rtl/cap_pkg.sv
package cap_pkg;

    typedef enum logic [1:0] {
        CAP_IDLE  = 2'd0,
        CAP_ARMED = 2'd1,
        CAP_POST  = 2'd2
    } cap_state_e;

    // Limit a requested post-trigger count so the trigger sample survives.
    function automatic logic [31:0] clamp_post(input logic [31:0] req,
                                               input logic [31:0] depth);
        return (req >= depth) ? (depth - 32'd1) : req;
    endfunction

endpackage

// File: rtl/cap_ctrl.sv
module cap_ctrl
    import cap_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int CNT_W = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic [CNT_W-1:0] post_count,
    input  logic             smp_valid,
    input  logic             trig,
    output logic             wen,
    output logic [AW-1:0]    wptr,
    output logic [AW-1:0]    trig_addr,
    output logic             done
);

    cap_state_e    state;
    logic [AW-1:0] remain;
    logic          fire;

    assign wen  = !arm && smp_valid &&
                  ((state == CAP_ARMED) || (state == CAP_POST && remain != '0));
    assign fire = !arm && (state == CAP_ARMED) && smp_valid && trig;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= CAP_IDLE;
            wptr      <= '0;
            remain    <= '0;
            trig_addr <= '0;
            done      <= 1'b0;
        end else if (arm) begin
            state  <= CAP_ARMED;
            wptr   <= '0;
            remain <= AW'(clamp_post(32'(post_count), 32'(DEPTH)));
            done   <= 1'b0;
        end else begin
            if (wen) wptr <= wptr + AW'(1);
            case (state)
                CAP_ARMED: begin
                    if (fire) begin
                        trig_addr <= wptr;
                        state     <= CAP_POST;
                    end
                end
                CAP_POST: begin
                    if (remain == '0) begin
                        state <= CAP_IDLE;
                        done  <= 1'b1;
                    end else if (smp_valid) begin
                        remain <= remain - AW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // R1
    idle_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (state == CAP_IDLE) |-> !wen);

    // R3
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (wen && !arm) |=> (wptr == $past(wptr) + AW'(1)));

    // R8
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wen && !arm) |=> $stable(wptr));

    // R5
    done_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !wen);

    // R7
    trig_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> $stable(trig_addr));

    // R2
    arm_clears_chk: assert property (@(posedge clk) disable iff (rst)
        arm |=> (!done && wptr == '0));

endmodule

// File: rtl/cap_mem.sv
module cap_mem #(
    parameter int DW    = 16,
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wen,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wen) store[waddr] <= wdata;
        rdata <= store[raddr];
    end

endmodule

// File: rtl/cap_rebase.sv
module cap_rebase #(
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic          done,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] rd_idx,
    output logic [AW-1:0] raddr,
    output logic          rd_valid
);

    // Power-of-two depth makes the modulo a plain truncating add.
    assign raddr = base + rd_idx;

    always_ff @(posedge clk) begin
        if (rst) rd_valid <= 1'b0;
        else     rd_valid <= rd_en && done;
    end

    // R10
    no_read_early_chk: assert property (@(posedge clk) disable iff (rst)
        !done |=> !rd_valid);

    // R9
    read_latency_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(rd_en));

endmodule

// File: rtl/ring_capture.sv
module ring_capture #(
    parameter int DW    = 16,
    parameter int DEPTH = 2048,
    parameter int CNT_W = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic [CNT_W-1:0] post_count,
    input  logic             smp_valid,
    input  logic [DW-1:0]    smp_data,
    input  logic             trig,
    output logic             done,
    output logic [AW-1:0]    trig_addr,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_idx,
    output logic             rd_valid,
    output logic [DW-1:0]    rd_data
);

    logic          wen;
    logic [AW-1:0] wptr;
    logic [AW-1:0] raddr;

    initial begin : depth_pow2
        assert (DEPTH == (1 << AW));
    end

    cap_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst(rst), .arm(arm), .post_count(post_count),
        .smp_valid(smp_valid), .trig(trig), .wen(wen), .wptr(wptr),
        .trig_addr(trig_addr), .done(done)
    );

    cap_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
        .clk(clk), .wen(wen), .waddr(wptr), .wdata(smp_data),
        .raddr(raddr), .rdata(rd_data)
    );

    cap_rebase #(.DEPTH(DEPTH)) u_rebase (
        .clk(clk), .rst(rst), .rd_en(rd_en), .done(done), .base(wptr),
        .rd_idx(rd_idx), .raddr(raddr), .rd_valid(rd_valid)
    );

    // R4
    trig_inside_record_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (trig_addr != wptr || $past(wen) == 1'b0));

endmodule

// File: tb/test_ring_capture.sv
module test_ring_capture;

    localparam int DW    = 16;
    localparam int DEPTH = 16;
    localparam int CNT_W = 16;
    localparam int AW    = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             arm = 1'b0;
    logic [CNT_W-1:0] post_count = '0;
    logic             smp_valid = 1'b0;
    logic [DW-1:0]    smp_data = '0;
    logic             trig = 1'b0;
    logic             done;
    logic [AW-1:0]    trig_addr;
    logic             rd_en = 1'b0;
    logic [AW-1:0]    rd_idx = '0;
    logic             rd_valid;
    logic [DW-1:0]    rd_data;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    ring_capture #(.DW(DW), .DEPTH(DEPTH), .CNT_W(CNT_W)) i_ring_capture (
        .clk(clk), .rst(rst), .arm(arm), .post_count(post_count),
        .smp_valid(smp_valid), .smp_data(smp_data), .trig(trig),
        .done(done), .trig_addr(trig_addr), .rd_en(rd_en), .rd_idx(rd_idx),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // {trigger position, programmed post count, effective post count, gaps}
    localparam int unsigned SCN [5][4] = '{
        '{20, 5,  5,  0},
        '{15, 0,  0,  0},
        '{40, 15, 15, 0},
        '{30, 63, 15, 0},
        '{25, 6,  6,  1}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input bit v, input logic [DW-1:0] d, input bit t);
        smp_valid = v;
        smp_data  = d;
        trig      = t;
        @(negedge clk);
        smp_valid = 1'b0;
        trig      = 1'b0;
    endtask

    task automatic do_arm(input int unsigned pc);
        arm = 1'b1;
        post_count = CNT_W'(pc);
        step(1'b1, 16'hA5A5, 1'b1);
        arm = 1'b0;
        post_count = 16'h0003;
        chk(done == 1'b0, "R2 done cleared by arm", int'(done), 0);
    endtask

    task automatic run_scn(input int idx, input int unsigned t_pos,
                           input int unsigned pc, input int unsigned n_post,
                           input bit gaps);
        int unsigned total;
        logic [DW-1:0] tag;
        int g;
        tag = DW'(idx << 8);
        do_arm(pc);
        rd_en = 1'b1;
        rd_idx = '0;
        step(1'b0, '0, 1'b0);
        rd_en = 1'b0;
        chk(rd_valid == 1'b0, "R10 read before done", int'(rd_valid), 0);
        g = 0;
        for (int unsigned s = 0; s <= t_pos; s++) begin
            if (gaps) begin
                // R8: invalid cycle carrying a trigger must be ignored
                step(1'b0, 16'hDEAD, 1'b1);
                g++;
            end
            step(1'b1, tag + DW'(s), s == t_pos);
            chk(done == 1'b0, "R5 done low before post samples", int'(done), 0);
        end
        for (int unsigned k = 0; k < n_post; k++) begin
            if (gaps) step(1'b0, 16'hDEAD, 1'b1);
            // R7: trigger during the post phase is ignored
            step(1'b1, tag + DW'(t_pos + 1 + k), k == 0);
            chk(done == 1'b0, "R5 done low during post", int'(done), 0);
        end
        step(1'b0, '0, 1'b0);
        chk(done == 1'b1, "R5 done one clock after last write", int'(done), 1);
        // R7 R8: samples and triggers after done must not alter the record
        for (int e = 0; e < 3; e++) step(1'b1, 16'hBEEF, 1'b1);
        chk(trig_addr == AW'(t_pos), "R4 trigger address", int'(trig_addr), int'(t_pos % DEPTH));
        total = t_pos + 1 + n_post;
        for (int i = 0; i < DEPTH; i++) begin
            rd_en = 1'b1;
            rd_idx = AW'(i);
            @(negedge clk);
            rd_en = 1'b0;
            chk(rd_valid == 1'b1, "R9 rd_valid", int'(rd_valid), 1);
            chk(rd_data == tag + DW'(total - DEPTH + i), "R9 R3 R6 ordered readout",
                int'(rd_data), int'(tag + DW'(total - DEPTH + i)));
        end
    endtask

    initial begin
        #(4 * 100000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=hang expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1
        chk(done == 1'b0, "R1 done after reset", int'(done), 0);
        chk(rd_valid == 1'b0, "R1 rd_valid after reset", int'(rd_valid), 0);
        // R7 R1: triggers and samples before any arm do nothing
        for (int i = 0; i < 4; i++) step(1'b1, 16'h1111, 1'b1);
        chk(done == 1'b0, "R7 idle trigger ignored", int'(done), 0);
        rd_en = 1'b1;
        step(1'b0, '0, 1'b0);
        rd_en = 1'b0;
        chk(rd_valid == 1'b0, "R10 read while idle", int'(rd_valid), 0);
        // R2: re-arm in the middle of the post phase
        do_arm(10);
        for (int i = 0; i < 6; i++) step(1'b1, 16'h2200, i == 2);
        do_arm(4);
        for (int i = 0; i < 3; i++) step(1'b1, 16'h2200, 1'b0);
        chk(done == 1'b0, "R2 re-arm restarts capture", int'(done), 0);
        for (int n = 0; n < 5; n++)
            run_scn(n + 1, SCN[n][0], SCN[n][1], SCN[n][2], SCN[n][3] != 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule